// File: doc/BRIEF.md
# Comma Word Aligner

This block receives a recovered serial bit stream, one bit on each cycle where the bit enable is high, and turns it into 10-bit characters. Bit 0 of a character is the earliest bit received. Characters come in pairs. A word clock runs at one twentieth of the bit rate: it rises with the even character of a pair and falls with the odd one, so downstream logic can capture the two halves on opposite clock edges.

While the alignment enable is high, the block searches every bit position for the seven-bit comma sequence 0,0,1,1,1,1,1, taken in arrival order. A comma is correctly placed only when it fills character bits 0 to 6 and lands on the odd character of a pair. If a comma is found anywhere else, the block moves the character boundary, and the pair phase if needed. It does this only by holding the current character longer before the next strobe; it never shortens a character period. A comma flag accompanies each correctly placed comma character. While the enable is low, the existing framing is kept unchanged whatever the data.

Top module: `comma_word_aligner`

## Requirements
- R1: Emitted character bit i is the i-th earliest bit of its 10-bit group. From reset until the first realignment, characters are back-to-back groups of 10 bits, starting with the first enabled bit after reset.
- R2: `char_stb` is a single-cycle pulse, one clock after the enabled bit that completes a character. `char_data` and `word_clk` hold their values between strobes. After reset all outputs are 0.
- R3: `word_clk` goes to 1 with an even character and to 0 with an odd one, and toggles at every strobe. The first character after reset is even.
- R4: While `align_en` is high, every character emitted that holds the comma has it in bits 6..0 = 7'b1111100 (bit 0 = 0, bit 1 = 0, bits 2..6 = 1) and is an odd character (`word_clk` = 0).
- R5: When a comma completes on an enabled bit, `align_en` is high on that bit, and e elapsed bits have been received since the last strobe (counting this bit), the next strobe comes 3 bits later. It comes 10 bits later still if e+3 < 10, in which case the comma character is dropped. Any strobe that was due in between is cancelled.
- R6: If the strobe scheduled under R5 would carry the wrong pair phase (odd for the comma character, even for the character after a dropped comma), it is delayed by one more full 10-bit character.
- R7: Consecutive strobes are never fewer than 10 enabled bits apart.
- R8: While `align_en` is low, strobes stay exactly 10 enabled bits apart whatever the data, and `comma_det` stays 0.
- R9: `comma_det` is set at a strobe when `align_en` was high on the completing bit and the character's bits 6..0 equal the comma. It is cleared at the next strobe without a comma.
- R10: A comma that is already correctly placed (e = 7, arriving on the odd half) does not change strobe timing.
- R11: Cycles with `bit_en` low neither advance the framing nor produce strobes. Results counted in enabled bits do not depend on such gaps.
- R12: After a realignment, every following character is the correct aligned 10-bit group, strobed every 10 bits, with the phase alternating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies `bit_in` as one received bit |
| bit_in | input | 1 | Serial data bit |
| align_en | input | 1 | Enables comma search, realignment and the comma flag |
| char_data | output | 10 | Current character, bit 0 earliest received |
| char_stb | output | 1 | One-cycle pulse marking a new character |
| word_clk | output | 1 | Pair clock: 1 after an even character, 0 after an odd one |
| comma_det | output | 1 | High while the current character is an aligned comma |

## Verification
The main pattern is a comma-bearing idle stream, an alternating filler followed by repeated comma/data character pairs. The comma is placed at each of the twenty bit offsets within a two-character word. Each offset separates four behaviours: the no-change case, a pure bit-offset stretch, a stretch that adds a phase flip, and a dropped comma character. Half of the offsets are repeated with idle bit-enable gaps to show that framing counts bits, not cycles. Streams with the enable low, one with a misaligned comma and one with a correctly placed comma, show that framing is frozen and the flag is suppressed.

// File: rtl/comma_align_pkg.sv
// Shared definitions for the comma word aligner.
// Assumes: characters are built least-significant-bit first (bit 0 earliest).
package comma_align_pkg;

    // Default character and comma geometry.
    localparam int unsigned DEF_CHAR_W  = 10;
    localparam int unsigned DEF_COMMA_W = 7;
    // Comma in arrival order: bit 0 earliest = 0, bit 1 = 0, bits 2..6 = 1.
    localparam logic [DEF_COMMA_W-1:0] DEF_COMMA_PAT = 7'b1111100;

    // Decision taken by the boundary controller on a clock cycle.
    typedef enum logic [1:0] {
        SLOT_IDLE    = 2'd0,  // no enabled bit this cycle
        SLOT_ADVANCE = 2'd1,  // bit absorbed into the current character
        SLOT_EMIT    = 2'd2,  // bit completes a character
        SLOT_RESYNC  = 2'd3   // comma seen: boundary rescheduled
    } slot_e;

endpackage

// File: rtl/cwa_bit_window.sv
// Sliding window of the most recent received bits.
// Provides the window including the bit arriving this cycle (oldest at bit 0).
// Assumes: bit_in is only meaningful when bit_en is high.
module cwa_bit_window #(
    parameter int unsigned CHAR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic [CHAR_W-1:0] win_next
);

    logic [CHAR_W-2:0] hist_q;

    // Newest bit enters at the top, oldest sits at bit 0.
    always_comb begin
        win_next = {bit_in, hist_q};
    end

    // Keep the CHAR_W-1 most recent bits for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (bit_en) begin
            hist_q <= win_next[CHAR_W-1:1];
        end
    end

endmodule

// File: rtl/cwa_comma_scan.sv
// Bitwise comparison of a slice of the window against the comma pattern.
// Instantiated once on the newest bits (stream search) and once on the
// oldest bits (character flag).
// Assumes: slice bit 0 is the earliest received bit of the slice.
module cwa_comma_scan #(
    parameter int unsigned          PAT_W = 7,
    parameter logic [PAT_W-1:0]     PAT   = 7'b1111100
) (
    input  logic [PAT_W-1:0] slice,
    output logic             hit
);

    logic [PAT_W-1:0] eq;

    // One equality term per pattern position.
    for (genvar g = 0; g < PAT_W; g++) begin : g_cmp
        assign eq[g] = (slice[g] == PAT[g]);
    end

    // All positions must agree.
    always_comb begin
        hit = &eq;
    end

endmodule

// File: rtl/cwa_boundary_ctrl.sv
// Character boundary and pair-phase scheduler.
// Counts bits left in the current character. A comma seen with alignment
// enabled reschedules the next boundary. The period is only ever lengthened:
// the boundary moves to 3 bits after the comma, plus one character when the
// comma character would fall short, plus one more when the phase is wrong.
// Assumes: comma_hit refers to the window including the current bit.
module cwa_boundary_ctrl
    import comma_align_pkg::*;
#(
    parameter int unsigned CHAR_W  = 10,
    parameter int unsigned COMMA_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic align_en,
    input  logic comma_hit,
    output logic emit,
    output logic emit_odd
);

    localparam int unsigned OFFSET = CHAR_W - COMMA_W;
    localparam int unsigned REM_W  = $clog2(3 * CHAR_W + 1);
    localparam int unsigned EL_W   = $clog2(CHAR_W + 1);

    logic [REM_W-1:0] remain_q, remain_d, resync_rem;
    logic [EL_W-1:0]  elapsed_q, elapsed_d, el_inc;
    logic             odd_q, odd_d;
    logic             short_c, want_odd, next_odd;
    slot_e            slot;

    // Bits since the last boundary, saturating once a full character is seen.
    always_comb begin
        el_inc = (elapsed_q >= EL_W'(CHAR_W)) ? elapsed_q : elapsed_q + 1'b1;
    end

    // Distance to the rescheduled boundary after a comma.
    always_comb begin
        next_odd   = !odd_q;
        short_c    = (REM_W'(el_inc) + REM_W'(OFFSET)) < REM_W'(CHAR_W);
        want_odd   = !short_c;
        resync_rem = REM_W'(OFFSET)
                   + (short_c ? REM_W'(CHAR_W) : '0)
                   + ((next_odd != want_odd) ? REM_W'(CHAR_W) : '0);
    end

    // Classify this cycle; a comma overrides a boundary due on the same bit.
    always_comb begin
        if (!bit_en) begin
            slot = SLOT_IDLE;
        end else if (align_en && comma_hit) begin
            slot = SLOT_RESYNC;
        end else if (remain_q == REM_W'(1)) begin
            slot = SLOT_EMIT;
        end else begin
            slot = SLOT_ADVANCE;
        end
    end

    // Next-state values for the counters and the phase.
    always_comb begin
        remain_d  = remain_q;
        elapsed_d = elapsed_q;
        odd_d     = odd_q;
        unique case (slot)
            SLOT_IDLE: begin
            end
            SLOT_ADVANCE: begin
                remain_d  = remain_q - 1'b1;
                elapsed_d = el_inc;
            end
            SLOT_EMIT: begin
                remain_d  = REM_W'(CHAR_W);
                elapsed_d = '0;
                odd_d     = next_odd;
            end
            SLOT_RESYNC: begin
                remain_d  = resync_rem;
                elapsed_d = el_inc;
            end
        endcase
    end

    // Boundary strobe and the phase that character takes.
    always_comb begin
        emit     = (slot == SLOT_EMIT);
        emit_odd = next_odd;
    end

    // Scheduler state; the phase starts odd so the first character is even.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q  <= REM_W'(CHAR_W);
            elapsed_q <= '0;
            odd_q     <= 1'b1;
        end else begin
            remain_q  <= remain_d;
            elapsed_q <= elapsed_d;
            odd_q     <= odd_d;
        end
    end

endmodule

// File: rtl/cwa_char_stage.sv
// Output register stage: captures the character, strobe, pair clock and
// comma flag on each boundary and holds them until the next one.
// Assumes: emit is a single-cycle request tied to an enabled bit.
module cwa_char_stage #(
    parameter int unsigned CHAR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic              emit_odd,
    input  logic              align_en,
    input  logic              low_hit,
    input  logic [CHAR_W-1:0] win_next,
    output logic [CHAR_W-1:0] char_data,
    output logic              char_stb,
    output logic              word_clk,
    output logic              comma_det
);

    // Strobe follows the boundary request by one register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_stb <= 1'b0;
        end else begin
            char_stb <= emit;
        end
    end

    // Character, pair clock and flag change only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_data <= '0;
            word_clk  <= 1'b0;
            comma_det <= 1'b0;
        end else if (emit) begin
            char_data <= win_next;
            word_clk  <= !emit_odd;
            comma_det <= align_en && low_hit;
        end
    end

endmodule

// File: rtl/comma_word_aligner.sv
// Top level of the comma word aligner.
// Builds characters from a bit-enabled serial stream, searches for the comma
// while align_en is high, and realigns by stretching character periods.
// Assumes: one received bit per cycle with bit_en high; reset is synchronous.
module comma_word_aligner
    import comma_align_pkg::*;
#(
    parameter int unsigned          CHAR_W    = DEF_CHAR_W,
    parameter int unsigned          COMMA_W   = DEF_COMMA_W,
    parameter logic [COMMA_W-1:0]   COMMA_PAT = DEF_COMMA_PAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              align_en,
    output logic [CHAR_W-1:0] char_data,
    output logic              char_stb,
    output logic              word_clk,
    output logic              comma_det
);

    localparam int unsigned OFFSET = CHAR_W - COMMA_W;

    logic [CHAR_W-1:0] win_next;
    logic              top_hit, low_hit, emit, emit_odd;

    cwa_bit_window #(.CHAR_W(CHAR_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .win_next (win_next)
    );

    // Search on the newest bits of the stream.
    cwa_comma_scan #(.PAT_W(COMMA_W), .PAT(COMMA_PAT)) u_scan_top (
        .slice (win_next[CHAR_W-1:OFFSET]),
        .hit   (top_hit)
    );

    // Flag check on the oldest bits, i.e. character bits 0..COMMA_W-1.
    cwa_comma_scan #(.PAT_W(COMMA_W), .PAT(COMMA_PAT)) u_scan_low (
        .slice (win_next[COMMA_W-1:0]),
        .hit   (low_hit)
    );

    cwa_boundary_ctrl #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .align_en  (align_en),
        .comma_hit (top_hit),
        .emit      (emit),
        .emit_odd  (emit_odd)
    );

    cwa_char_stage #(.CHAR_W(CHAR_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (emit),
        .emit_odd  (emit_odd),
        .align_en  (align_en),
        .low_hit   (low_hit),
        .win_next  (win_next),
        .char_data (char_data),
        .char_stb  (char_stb),
        .word_clk  (word_clk),
        .comma_det (comma_det)
    );

endmodule

// File: rtl/comma_word_aligner_chk.sv
// Property checker for the comma word aligner, attached by bind.
// Tracks enabled bits between strobes and whether alignment was enabled.
module comma_word_aligner_chk #(
    parameter int unsigned          CHAR_W    = 10,
    parameter int unsigned          COMMA_W   = 7,
    parameter logic [COMMA_W-1:0]   COMMA_PAT = 7'b1111100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              align_en,
    input logic [CHAR_W-1:0] char_data,
    input logic              char_stb,
    input logic              word_clk,
    input logic              comma_det
);

    logic [6:0] gap_q;
    logic       seen_align_q;

    // Count enabled bits since the previous strobe cycle, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (char_stb) begin
            gap_q <= bit_en ? 7'd1 : 7'd0;
        end else if (bit_en && gap_q != 7'h7F) begin
            gap_q <= gap_q + 7'd1;
        end
    end

    // Remember whether alignment was enabled since the previous strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_align_q <= 1'b0;
        end else if (char_stb) begin
            seen_align_q <= align_en;
        end else begin
            seen_align_q <= seen_align_q | align_en;
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        char_stb |=> !char_stb); // R2
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !char_stb |-> ($stable(char_data) && $stable(word_clk))); // R2
    AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        char_stb |-> (word_clk != $past(word_clk))); // R3
    AST_COMMA_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        comma_det |-> (char_data[COMMA_W-1:0] == COMMA_PAT)); // R4
    AST_COMMA_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        comma_det |-> !word_clk); // R4
    AST_NO_SLIVER: assert property (@(posedge clk) disable iff (!rst_n)
        char_stb |-> (gap_q >= 7'(CHAR_W))); // R7
    AST_FIXED_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && !seen_align_q) |-> (gap_q == 7'(CHAR_W))); // R8
    AST_COMMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && comma_det) |-> $past(align_en)); // R9

endmodule

bind comma_word_aligner comma_word_aligner_chk #(
    .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .align_en  (align_en),
    .char_data (char_data),
    .char_stb  (char_stb),
    .word_clk  (word_clk),
    .comma_det (comma_det)
);

// File: tb/comma_word_aligner_tb_top.sv
`timescale 1ns/1ps
module comma_word_aligner_tb_top;

    localparam logic [6:0] PAT = 7'b1111100;
    localparam int NWORDS = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       align_en = 1'b0;
    logic [9:0] char_data;
    logic       char_stb, word_clk, comma_det;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    logic       stream [0:255];
    int         slen;
    int         em_idx [0:63];
    logic [9:0] em_dat [0:63];
    logic       em_wc  [0:63];
    logic       em_cd  [0:63];
    int         em_n;
    int         last_idx, next_idx;

    always #2 clk = ~clk;

    comma_word_aligner dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .align_en(align_en), .char_data(char_data), .char_stb(char_stb),
        .word_clk(word_clk), .comma_det(comma_det)
    );

    // Watchdog: an expired run is a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Sample outputs of the previous edge, then drive the next input.
    task automatic step(input logic en, input logic b);
        @(negedge clk);
        if (char_stb) begin
            if (em_n < 64) begin
                em_idx[em_n] = last_idx;
                em_dat[em_n] = char_data;
                em_wc[em_n]  = word_clk;
                em_cd[em_n]  = comma_det;
            end
            em_n++;
        end
        bit_en = en;
        bit_in = b;
        if (en) begin
            last_idx = next_idx;
            next_idx++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_en = 1'b0;
        bit_in = 1'b0;
        repeat (2) @(negedge clk);
        chk(char_stb == 1'b0, "R2 reset strobe", int'(char_stb), 0);
        chk(word_clk == 1'b0, "R3 reset word_clk", int'(word_clk), 0);
        chk(comma_det == 1'b0, "R9 reset flag", int'(comma_det), 0);
        chk(char_data == 10'd0, "R1 reset data", int'(char_data), 0);
        rst_n = 1'b1;
        em_n = 0;
        next_idx = 0;
        last_idx = -1;
    endtask

    // Alternating filler of length flen, then comma/data character pairs.
    task automatic build(input int flen);
        logic [9:0] kch;
        logic [9:0] dch;
        kch = 10'b0101111100;  // bit0 first: 0,0,1,1,1,1,1,0,1,0
        dch = 10'b0101010101;  // bit0 first: 1,0,1,0,...
        for (int i = 0; i < flen; i++) stream[i] = logic'(i % 2);
        for (int w = 0; w < NWORDS; w++) begin
            for (int b = 0; b < 10; b++) begin
                stream[flen + 20*w + b]      = kch[b];
                stream[flen + 20*w + 10 + b] = dch[b];
            end
        end
        slen = flen + 20*NWORDS;
    endtask

    task automatic send(input bit aen, input bit gaps);
        align_en = aen;
        for (int i = 0; i < slen; i++) begin
            step(1'b1, stream[i]);
            if (gaps && (i % 3 == 2)) step(1'b0, 1'b0);
        end
        repeat (3) step(1'b0, 1'b0);
    endtask

    function automatic logic [9:0] exp_char(input int idx);
        logic [9:0] v;
        for (int b = 0; b < 10; b++) v[b] = stream[idx - 9 + b];
        return v;
    endfunction

    // Realignment run: comma starts at bit flen.
    task automatic run_align(input int flen, input bit gaps);
        int p, bb, n, el, e, post_n, eidx, jj;
        bit nxt_odd, shortc, req_odd, odd;
        logic [9:0] ed;
        logic ecd;
        string tag;
        build(flen);
        do_reset();
        send(1'b1, gaps);
        p = flen + 6;
        bb = 10 * ((p - 10) / 10) + 9;
        n = (bb + 1) / 10;
        nxt_odd = (n % 2) == 1;
        el = p - bb;
        shortc = (el + 3) < 10;
        req_odd = !shortc;
        e = p + 3 + (shortc ? 10 : 0) + ((nxt_odd != req_odd) ? 10 : 0);
        post_n = (slen - 1 - e) / 10 + 1;
        chk(em_n == n + post_n, gaps ? "R11 strobe count with gaps" : "R12 strobe count",
            em_n, n + post_n);
        for (int j = 0; j < em_n && j < 64; j++) begin
            if (j < n) begin
                eidx = 10*j + 9;
                odd = (j % 2) == 1;
                tag = "R1";
            end else begin
                jj = j - n;
                eidx = e + 10*jj;
                odd = nxt_odd ^ ((jj % 2) == 1);
                if (jj > 0) tag = "R12";
                else if (nxt_odd != req_odd) tag = "R6";
                else if (el == 7) tag = "R10";
                else tag = "R5";
            end
            ed = exp_char(eidx);
            ecd = (ed[6:0] == PAT);
            chk(em_idx[j] == eidx, {tag, " strobe position"}, em_idx[j], eidx);
            chk(em_dat[j] == ed, {tag, " character data"}, int'(em_dat[j]), int'(ed));
            chk(em_wc[j] == !odd, ecd ? "R4 comma phase" : "R3 pair phase",
                int'(em_wc[j]), int'(!odd));
            chk(em_cd[j] == ecd, "R9 comma flag", int'(em_cd[j]), int'(ecd));
            if (j > 0)
                chk(em_idx[j] - em_idx[j-1] >= 10, "R7 period not shortened",
                    em_idx[j] - em_idx[j-1], 10);
        end
    endtask

    // Alignment disabled: framing frozen, flag silent.
    task automatic run_frozen(input int flen);
        logic [9:0] ed;
        build(flen);
        do_reset();
        send(1'b0, 1'b0);
        chk(em_n == slen / 10, "R8 strobe count", em_n, slen / 10);
        for (int j = 0; j < em_n && j < 64; j++) begin
            ed = exp_char(10*j + 9);
            chk(em_idx[j] == 10*j + 9, "R8 fixed position", em_idx[j], 10*j + 9);
            chk(em_dat[j] == ed, "R8 character data", int'(em_dat[j]), int'(ed));
            chk(em_wc[j] == ((j % 2) == 0), "R3 pair phase", int'(em_wc[j]), int'((j % 2) == 0));
            chk(em_cd[j] == 1'b0, "R9 flag off when disabled", int'(em_cd[j]), 0);
        end
    endtask

    initial begin
        for (int k = 0; k < 20; k++) run_align(20 + k, (k % 2) == 1);
        run_frozen(23);
        run_frozen(30);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule